// File: doc/BRIEF.md
# Bidirectional GPIO Port with Direction and Value Overrides

This block is an 8-bit general-purpose I/O port that sits on a simple register bus. Software controls it through three addresses: a direction register, an output latch and a pin-sample register. Each pad gets an output value, an output enable and an input path that passes through a synchronizer.

On top of the software view, peripherals can take over the direction or the output value of any pin, one bit at a time. A system-bus-enable input hands every pin except bit 5 to an external-memory controller. None of these overrides is ever written back into the direction register, so software can read, modify and write that register safely while a peripheral or the bus holds the pins.

Register addresses are 0 for direction, 1 for the output latch and 2 for the pin sample. Address 3 is unmapped. Reads are combinational on the address.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset the direction register reads 0xFF, the output latch reads 0x00 and pad_oe is 0x00, so every pin is an input.
- R2: With no override and the system bus disabled, a direction bit of 1 gives pad_oe=0 for that pin and a direction bit of 0 gives pad_oe=1. pad_out carries the output latch bit.
- R3: A read of address 1 returns the stored output latch, not the level on pad_in.
- R4: A read of address 2 returns pad_in as sampled through two clocked stages. A change driven between edges is visible after the second rising edge and not after the first.
- R5: A write to address 2 loads the output latch, and a write to address 1 also loads it.
- R6: Where ovr_dir_en[i]=1, pad_oe[i] follows ovr_dir_out[i] (1 = output), whatever the direction bit. The direction register keeps its software-written value.
- R7: Where ovr_val_en[i]=1 and the pin is not owned by the bus, pad_out[i] is ovr_val[i] instead of the latch bit.
- R8: While sysbus_en=1, every pin except bit 5 takes pad_oe and pad_out from sysbus_oe and sysbus_out, ahead of any peripheral override. Bit 5 stays under port and peripheral control.
- R9: Writing 0xCF to the direction register makes pad_oe equal 0x30: bits 5:4 are outputs and the rest are inputs.
- R10: The output latch is independent of direction. A value written while a pin is an input appears on pad_out with pad_oe=1 once the direction bit is cleared.
- R11: A read of address 3 returns 0x00. A write to address 3 changes neither the direction register nor the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational on reg_addr |
| pad_in | input | 8 | Pin level from the pads |
| pad_out | output | 8 | Value to drive on the pads |
| pad_oe | output | 8 | Per-pin output enable (1 = drive) |
| ovr_dir_en | input | 8 | Per-pin peripheral direction override enable |
| ovr_dir_out | input | 8 | Forced direction when overridden (1 = output) |
| ovr_val_en | input | 8 | Per-pin peripheral output value override enable |
| ovr_val | input | 8 | Forced output value |
| sysbus_en | input | 1 | External system bus owns the bus pins |
| sysbus_oe | input | 8 | Output enables from the memory controller |
| sysbus_out | input | 8 | Output values from the memory controller |

## Verification
The bench builds the block with its defaults: width 8, bus-free pin 5 and two synchronizer stages. With these values the 0xCF direction pattern, the bit-5 exemption and the two-edge delay on a pin read can all be checked against exact values. A vector table covers the priority between bus ownership, peripheral overrides and the direction register. Combinations are chosen so that each level of priority decides at least one bit. Directed steps then cover the reset values, the latch read against a conflicting pad level, the synchronizer edge count and the unmapped address.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_DIR = 2'd0;
  localparam logic [ADDR_W-1:0] A_LAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_PIN = 2'd2;

  // Three-level priority pick: bus, then peripheral, then default.
  function automatic logic pick3(input logic bus_own, input logic bus_v,
                                 input logic per_en, input logic per_v,
                                 input logic dflt);
    if (bus_own)     return bus_v;
    else if (per_en) return per_v;
    else             return dflt;
  endfunction
endpackage

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
    // R4: each stage takes the previous stage one clock later
    p_sync_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stg[s] == $past(stg[s-1]));
  end

  // R4: first stage captures the pad level
  p_sync_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stg[0] == $past(d_in));

  assign q_out = stg[STAGES-1];
endmodule

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      pin_q,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      lat_q
);
  logic dir_we, lat_we;
  assign dir_we = wr && (addr == A_DIR);
  assign lat_we = wr && ((addr == A_LAT) || (addr == A_PIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '1;
    else if (dir_we) dir_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (lat_we) lat_q <= wdata;
  end

  always_comb begin
    case (addr)
      A_DIR:   rdata = dir_q;
      A_LAT:   rdata = lat_q;
      A_PIN:   rdata = pin_q;
      default: rdata = '0;
    endcase
  end

  // R1: reset leaves every pin an input
  p_reset_dir_r1: assert property (@(posedge clk) !rst_n |=> dir_q == '1);
  // R6: direction changes only through a software write
  p_dir_only_sw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == A_DIR) |=> $stable(dir_q));
  // R5: both latch addresses load the latch
  p_lat_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (addr == A_LAT || addr == A_PIN)) |=> lat_q == $past(wdata));
  // R11: unmapped address reads zero
  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd3) |-> rdata == '0);
endmodule

// File: rtl/gpio_ovr_padmux.sv
module gpio_ovr_padmux
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter logic [W-1:0] BUS_MASK = '1
) (
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] lat_q,
  input  logic [W-1:0] ovr_dir_en,
  input  logic [W-1:0] ovr_dir_out,
  input  logic [W-1:0] ovr_val_en,
  input  logic [W-1:0] ovr_val,
  input  logic         sysbus_en,
  input  logic [W-1:0] sysbus_oe,
  input  logic [W-1:0] sysbus_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] bus_own
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (BUS_MASK[i]) begin : g_shared
      assign bus_own[i] = sysbus_en;
    end else begin : g_free
      assign bus_own[i] = 1'b0;
    end
    assign pad_oe[i]  = pick3(bus_own[i], sysbus_oe[i], ovr_dir_en[i],
                              ovr_dir_out[i], ~dir_q[i]);
    assign pad_out[i] = pick3(bus_own[i], sysbus_out[i], ovr_val_en[i],
                              ovr_val[i], lat_q[i]);
  end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter int unsigned FREE_BIT = 5,
  parameter int unsigned SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  input  logic [W-1:0]      ovr_dir_en,
  input  logic [W-1:0]      ovr_dir_out,
  input  logic [W-1:0]      ovr_val_en,
  input  logic [W-1:0]      ovr_val,
  input  logic              sysbus_en,
  input  logic [W-1:0]      sysbus_oe,
  input  logic [W-1:0]      sysbus_out
);
  localparam logic [W-1:0] BUS_MASK = ~(W'(1) << FREE_BIT);

  logic [W-1:0] pin_q, dir_q, lat_q, bus_own;

  gpio_ovr_sync #(.W(W), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pad_in), .q_out(pin_q));

  gpio_ovr_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
    .wdata(reg_wdata), .pin_q(pin_q), .rdata(reg_rdata),
    .dir_q(dir_q), .lat_q(lat_q));

  gpio_ovr_padmux #(.W(W), .BUS_MASK(BUS_MASK)) u_mux (
    .dir_q(dir_q), .lat_q(lat_q), .ovr_dir_en(ovr_dir_en),
    .ovr_dir_out(ovr_dir_out), .ovr_val_en(ovr_val_en), .ovr_val(ovr_val),
    .sysbus_en(sysbus_en), .sysbus_oe(sysbus_oe), .sysbus_out(sysbus_out),
    .pad_oe(pad_oe), .pad_out(pad_out), .bus_own(bus_own));

  // R2: plain mode follows the inverted direction register
  p_dir_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sysbus_en && ovr_dir_en == '0) |-> pad_oe == ~dir_q);
  // R8: the bus-free pin is never owned by the bus
  p_free_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_own[FREE_BIT]);
  // R8: the free pin keeps the port direction while the bus is on
  p_free_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sysbus_en && !ovr_dir_en[FREE_BIT]) |-> pad_oe[FREE_BIT] == ~dir_q[FREE_BIT]);
  // R1: no pin drives in the first cycle after reset
  p_reset_oe_r1: assert property (@(posedge clk)
    (!rst_n && !sysbus_en && ovr_dir_en == '0) |=> (rst_n || pad_oe == '0));
endmodule

// File: tb/gpio_ovr_port_test.sv
`timescale 1ns/1ps
module gpio_ovr_port_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] reg_addr = 0;
  logic       reg_wr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [7:0] pad_in = 0, pad_out, pad_oe;
  logic [7:0] ovr_dir_en = 0, ovr_dir_out = 0, ovr_val_en = 0, ovr_val = 0;
  logic       sysbus_en = 0;
  logic [7:0] sysbus_oe = 0, sysbus_out = 0;

  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  gpio_ovr_port uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .ovr_dir_en(ovr_dir_en),
    .ovr_dir_out(ovr_dir_out), .ovr_val_en(ovr_val_en), .ovr_val(ovr_val),
    .sysbus_en(sysbus_en), .sysbus_oe(sysbus_oe), .sysbus_out(sysbus_out));

  // vector: dir lat ode odo ove ov sb sboe sbout exp_oe exp_out
  localparam int NV = 6;
  localparam logic [80:0] VEC [NV] = '{
    {8'hFF, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 8'h00, 8'hA5},
    {8'hCF, 8'h3C, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 8'h30, 8'h3C},
    {8'h00, 8'h5A, 8'h0F, 8'h05, 8'hF0, 8'hC0, 1'b0, 8'h00, 8'h00, 8'hF5, 8'hCA},
    {8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'hAA, 8'h0F, 8'h8A, 8'h2F},
    {8'h00, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00, 1'b1, 8'h00, 8'hFF, 8'h00, 8'hDF},
    {8'hDF, 8'h20, 8'h20, 8'h20, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 8'h20, 8'h20}
  };
  localparam string VTAG [NV] = '{"R2", "R9", "R6/R7", "R8", "R8", "R6"};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd_reg(2'd0, r); check("R1 dir", r, 8'hFF);
    rd_reg(2'd1, r); check("R1 lat", r, 8'h00);
    check("R1 oe", pad_oe, 8'h00);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      wr_reg(2'd0, VEC[v][80:73]);
      wr_reg(2'd1, VEC[v][72:65]);
      ovr_dir_en  = VEC[v][64:57];
      ovr_dir_out = VEC[v][56:49];
      ovr_val_en  = VEC[v][48:41];
      ovr_val     = VEC[v][40:33];
      sysbus_en   = VEC[v][32];
      sysbus_oe   = VEC[v][31:24];
      sysbus_out  = VEC[v][23:16];
      #1;
      check({VTAG[v], " oe"}, pad_oe, VEC[v][15:8]);
      check({VTAG[v], " out"}, pad_out, VEC[v][7:0]);
      rd_reg(2'd0, r);
      check({VTAG[v], " dir readback"}, r, VEC[v][80:73]);
      @(negedge clk);
    end
    ovr_dir_en = 0; ovr_val_en = 0; sysbus_en = 0;

    // R3: latch read ignores the pad level
    wr_reg(2'd1, 8'h66);
    pad_in = 8'h99;
    repeat (3) @(negedge clk);
    rd_reg(2'd1, r); check("R3 lat vs pin", r, 8'h66);

    // R4: two-edge synchronizer
    rd_reg(2'd2, r); check("R4 settled", r, 8'h99);
    pad_in = 8'h3E;
    @(negedge clk);
    rd_reg(2'd2, r); check("R4 after one edge", r, 8'h99);
    @(negedge clk);
    rd_reg(2'd2, r); check("R4 after two edges", r, 8'h3E);

    // R5: write through pin address hits the latch
    wr_reg(2'd2, 8'h77);
    rd_reg(2'd1, r); check("R5 lat via pin addr", r, 8'h77);

    // R10: latch survives a direction change
    wr_reg(2'd0, 8'hFF);
    wr_reg(2'd1, 8'h81);
    check("R10 oe input", pad_oe, 8'h00);
    wr_reg(2'd0, 8'h00);
    check("R10 oe", pad_oe, 8'hFF);
    check("R10 out", pad_out, 8'h81);

    // R11: unmapped address
    rd_reg(2'd3, r); check("R11 read", r, 8'h00);
    wr_reg(2'd3, 8'h5C);
    rd_reg(2'd0, r); check("R11 dir kept", r, 8'h00);
    rd_reg(2'd1, r); check("R11 lat kept", r, 8'h81);

    // R9 again after other traffic
    wr_reg(2'd0, 8'hCF);
    check("R9 oe", pad_oe, 8'h30);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule